// File: doc/BRIEF.md
# PWM Fault Input Filter and Shutdown

This block guards the six drive outputs of a three-phase motor inverter. It watches an external fault input and removes the drive when that input reports trouble. The raw input is first brought into the clock domain by two flip-flops. It is then sampled at a selectable fraction of the peripheral clock. A new level is accepted only when a fixed number of consecutive samples agree, so short glitches are discarded.

The filtered level feeds a detector that can respond to a falling edge, a rising edge, a low level or a high level. Edge faults stay latched until software clears them with a pulse. Level faults follow the filtered input, and a sticky flag records that the fault happened. When shutdown is enabled, a fault drops the registered output-enable of every PWM output, which puts the pads into high impedance. A separate force bit removes all drive at any time. Each output group, upper and lower, has its own polarity control.

The detection-mode setting is captured only while the PWM stage is idle. A request made while the stage is running is ignored.

Top module: `pwm_fault_guard`

## Requirements
- R1: A level change on the fault input is accepted only after 6 consecutive samples at the new level. A run of 5 or fewer differing samples changes nothing. The filtered level is high after reset.
- R2: The sample strobe occurs once every 2^sel clock cycles, where sel is the 3-bit `filt_div_sel` (0 gives every cycle, 7 gives every 128 cycles).
- R3: With mode code 00 (falling edge), a high-to-low change of the filtered level latches `fault_active`. The latch holds until a one-cycle `flag_clr` pulse. A new edge that arrives in the same cycle as the clear wins.
- R4: With mode code 01 (rising edge), a low-to-high change of the filtered level latches `fault_active` in the same way.
- R5: With mode code 10 (low level) or 11 (high level), `fault_active` follows whether the filtered level equals the active level. `fault_flag` is set by any detected fault and stays set until `flag_clr`.
- R6: While `det_en` is 0, no new fault is detected, and a level-mode fault reads 0.
- R7: When `shut_en` is 1, both output-enable groups go low on the same clock edge on which `fault_active` rises. When `shut_en` is 0, a fault leaves the enables high.
- R8: While `out_force_off` is 1, all output enables are low on the following clock edge, whatever the fault state.
- R9: Each registered PWM output equals its drive input XOR the group's polarity bit (0 gives low start level, 1 gives high start level), with one cycle of latency.
- R10: The mode request `act_type` is captured only in cycles where `pwm_run` is 0. While `pwm_run` is 1, the previous mode stays in force.
- R11: During reset, all outputs are 0, including the enables, the fault and the flag. The mode is falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pin | input | 1 | Raw asynchronous fault input |
| filt_div_sel | input | 3 | Filter sample-rate select, divide by 2^sel |
| act_type | input | 2 | Requested detection mode (00 fall, 01 rise, 10 low, 11 high) |
| pwm_run | input | 1 | PWM stage running; freezes the mode |
| det_en | input | 1 | Fault detection enable |
| shut_en | input | 1 | Drop output enables on fault |
| out_force_off | input | 1 | Drop all output enables unconditionally |
| pol_up | input | 1 | Upper group polarity |
| pol_dn | input | 1 | Lower group polarity |
| flag_clr | input | 1 | One-cycle clear of latched fault and sticky flag |
| pwm_up | input | 3 | Upper group drive signals |
| pwm_dn | input | 3 | Lower group drive signals |
| pwm_up_o | output | 3 | Registered upper outputs after polarity |
| pwm_dn_o | output | 3 | Registered lower outputs after polarity |
| pwm_up_oe | output | 3 | Upper output enables (0 = high impedance) |
| pwm_dn_oe | output | 3 | Lower output enables (0 = high impedance) |
| fault_active | output | 1 | Current fault state |
| fault_flag | output | 1 | Sticky fault record |

## Verification
Several properties are checked on every cycle: the mode is frozen while the stage runs, the filtered level moves only on a sample strobe, a latched edge fault and the sticky flag hold until cleared, detection stays quiet when it is disabled, and the enables follow the force and shutdown controls. Some behaviour can only be shown by the bench scenarios. These include whether a pulse of a given length survives the filter at each sample rate, which edge direction each mode accepts, and that a mode request made while running is really ignored. The behavioural model covers every cycle of these scenarios.

// File: rtl/pwm_fault_guard_pkg.sv
package pwm_fault_guard_pkg;
  typedef enum logic [1:0] {
    DET_FALL = 2'b00,
    DET_RISE = 2'b01,
    DET_LOW  = 2'b10,
    DET_HIGH = 2'b11
  } det_mode_e;

  function automatic logic mode_is_level(det_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_active_level(det_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_prescale.sv
module pfg_prescale #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(sel)) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign strobe = ((cnt & mask) == mask);
endmodule

// File: rtl/pfg_runlen.sv
module pfg_runlen #(
  parameter int RUN_LEN = 6,
  parameter logic RST_LVL = 1'b1,
  localparam int RC_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic din,
  output logic level
);
  logic [RC_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= RST_LVL;
      run   <= '0;
    end else if (strobe) begin
      if (din == level) begin
        run <= '0;
      end else if (run == RC_W'(RUN_LEN - 1)) begin
        level <= din;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfg_detect.sv
module pfg_detect
  import pwm_fault_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  input  logic [1:0] act_type,
  input  logic      pwm_run,
  input  logic      det_en,
  input  logic      flag_clr,
  output det_mode_e mode,
  output logic      fault_nxt,
  output logic      fault_q,
  output logic      flag_q
);
  logic level_d;
  logic edge_hit;
  logic cond;
  logic flag_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= DET_FALL;
      level_d <= 1'b1;
    end else begin
      level_d <= level;
      if (!pwm_run) mode <= det_mode_e'(act_type);
    end
  end

  always_comb begin
    unique case (mode)
      DET_FALL: edge_hit = level_d & ~level;
      DET_RISE: edge_hit = ~level_d & level;
      default:  edge_hit = 1'b0;
    endcase
    if (mode_is_level(mode)) begin
      cond      = det_en & (level == mode_active_level(mode));
      fault_nxt = cond;
    end else begin
      cond      = det_en & edge_hit;
      fault_nxt = cond | (fault_q & ~flag_clr);
    end
    flag_nxt = cond | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      fault_q <= fault_nxt;
      flag_q  <= flag_nxt;
    end
  end
endmodule

// File: rtl/pfg_outstage.sv
module pfg_outstage #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] drv,
  input  logic           pol,
  input  logic           kill,
  output logic [NPH-1:0] val,
  output logic [NPH-1:0] oe
);
  for (genvar g = 0; g < NPH; g++) begin : g_ph
    always_ff @(posedge clk) begin
      if (rst) begin
        val[g] <= 1'b0;
        oe[g]  <= 1'b0;
      end else begin
        val[g] <= drv[g] ^ pol;
        oe[g]  <= ~kill;
      end
    end
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_guard_pkg::*;
#(
  parameter int NPH     = 3,
  parameter int SEL_W   = 3,
  parameter int RUN_LEN = 6,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_pin,
  input  logic [SEL_W-1:0] filt_div_sel,
  input  logic [1:0]       act_type,
  input  logic             pwm_run,
  input  logic             det_en,
  input  logic             shut_en,
  input  logic             out_force_off,
  input  logic             pol_up,
  input  logic             pol_dn,
  input  logic             flag_clr,
  input  logic [NPH-1:0]   pwm_up,
  input  logic [NPH-1:0]   pwm_dn,
  output logic [NPH-1:0]   pwm_up_o,
  output logic [NPH-1:0]   pwm_dn_o,
  output logic [NPH-1:0]   pwm_up_oe,
  output logic [NPH-1:0]   pwm_dn_oe,
  output logic             fault_active,
  output logic             fault_flag
);
  logic      pin_s;
  logic      strobe;
  logic      filt;
  det_mode_e act_mode;
  logic      fault_nxt;
  logic      kill;

  pfg_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(fault_pin), .q(pin_s)
  );

  pfg_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .sel(filt_div_sel), .strobe(strobe)
  );

  pfg_runlen #(.RUN_LEN(RUN_LEN), .RST_LVL(1'b1)) u_filt (
    .clk(clk), .rst(rst), .strobe(strobe), .din(pin_s), .level(filt)
  );

  pfg_detect u_det (
    .clk(clk), .rst(rst), .level(filt), .act_type(act_type),
    .pwm_run(pwm_run), .det_en(det_en), .flag_clr(flag_clr),
    .mode(act_mode), .fault_nxt(fault_nxt), .fault_q(fault_active),
    .flag_q(fault_flag)
  );

  assign kill = out_force_off | (shut_en & fault_nxt);

  pfg_outstage #(.NPH(NPH)) u_up (
    .clk(clk), .rst(rst), .drv(pwm_up), .pol(pol_up), .kill(kill),
    .val(pwm_up_o), .oe(pwm_up_oe)
  );

  pfg_outstage #(.NPH(NPH)) u_dn (
    .clk(clk), .rst(rst), .drv(pwm_dn), .pol(pol_dn), .kill(kill),
    .val(pwm_dn_o), .oe(pwm_dn_oe)
  );
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           strobe,
  input logic           filt,
  input logic [1:0]     act_mode,
  input logic           pwm_run,
  input logic           det_en,
  input logic           shut_en,
  input logic           out_force_off,
  input logic           flag_clr,
  input logic           pol_up,
  input logic [NPH-1:0] pwm_up,
  input logic [NPH-1:0] pwm_up_o,
  input logic [NPH-1:0] pwm_up_oe,
  input logic [NPH-1:0] pwm_dn_oe,
  input logic           fault_active,
  input logic           fault_flag
);
  p_filt_on_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(strobe) |-> $stable(filt));

  p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fault_active) && !$past(flag_clr) && !$past(act_mode[1])
    |-> fault_active);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fault_flag) && !$past(flag_clr) |-> fault_flag);

  p_det_off_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(det_en) && !$past(fault_active) |-> !fault_active);

  p_shut_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(shut_en) && fault_active
    |-> (pwm_up_oe == '0) && (pwm_dn_oe == '0));

  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(shut_en) && !$past(out_force_off)
    |-> (&pwm_up_oe) && (&pwm_dn_oe));

  p_force_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(out_force_off)
    |-> (pwm_up_oe == '0) && (pwm_dn_oe == '0));

  p_pol_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pwm_up_o == ($past(pwm_up) ^ {NPH{$past(pol_up)}}));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(pwm_run) |-> act_mode == $past(act_mode));
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .filt(filt), .act_mode(act_mode),
  .pwm_run(pwm_run), .det_en(det_en), .shut_en(shut_en),
  .out_force_off(out_force_off), .flag_clr(flag_clr), .pol_up(pol_up),
  .pwm_up(pwm_up), .pwm_up_o(pwm_up_o), .pwm_up_oe(pwm_up_oe),
  .pwm_dn_oe(pwm_dn_oe), .fault_active(fault_active), .fault_flag(fault_flag)
);

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/1ps
module sim_pwm_fault_guard;
  localparam int NPH = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fault_pin = 1'b1;
  logic [2:0] filt_div_sel = 3'd0;
  logic [1:0] act_type = 2'b00;
  logic pwm_run = 1'b0, det_en = 1'b1, shut_en = 1'b1, out_force_off = 1'b0;
  logic pol_up = 1'b0, pol_dn = 1'b0, flag_clr = 1'b0;
  logic [NPH-1:0] pwm_up = '0, pwm_dn = '0;
  logic [NPH-1:0] pwm_up_o, pwm_dn_o, pwm_up_oe, pwm_dn_oe;
  logic fault_active, fault_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_fault_guard u0 (
    .clk(clk), .rst(rst), .fault_pin(fault_pin), .filt_div_sel(filt_div_sel),
    .act_type(act_type), .pwm_run(pwm_run), .det_en(det_en), .shut_en(shut_en),
    .out_force_off(out_force_off), .pol_up(pol_up), .pol_dn(pol_dn),
    .flag_clr(flag_clr), .pwm_up(pwm_up), .pwm_dn(pwm_dn),
    .pwm_up_o(pwm_up_o), .pwm_dn_o(pwm_dn_o), .pwm_up_oe(pwm_up_oe),
    .pwm_dn_oe(pwm_dn_oe), .fault_active(fault_active), .fault_flag(fault_flag)
  );

  // Behavioural reference model
  int m_hist[$];
  int m_cyc, m_run, m_filt, m_prev, m_mode, m_fault, m_flag, m_oe;
  int m_up, m_dn;

  always @(posedge clk) begin
    if (rst) begin
      m_hist = {1, 1};
      m_cyc = 0; m_run = 0; m_filt = 1; m_prev = 1; m_mode = 0;
      m_fault = 0; m_flag = 0; m_oe = 0; m_up = 0; m_dn = 0;
    end else begin
      int div, samp, hit, cond, nf;
      div  = 1 << filt_div_sel;
      samp = m_hist[0];
      hit  = 0;
      if (m_mode == 0 && m_prev == 1 && m_filt == 0) hit = 1;
      if (m_mode == 1 && m_prev == 0 && m_filt == 1) hit = 1;
      if (m_mode >= 2) begin
        cond = (det_en && m_filt == (m_mode % 2)) ? 1 : 0;
        nf = cond;
      end else begin
        cond = (det_en && hit) ? 1 : 0;
        nf = (cond || (m_fault && !flag_clr)) ? 1 : 0;
      end
      m_flag = (cond || (m_flag && !flag_clr)) ? 1 : 0;
      m_fault = nf;
      m_oe = (out_force_off || (shut_en && nf)) ? 0 : 1;
      m_up = int'(pwm_up ^ {NPH{pol_up}});
      m_dn = int'(pwm_dn ^ {NPH{pol_dn}});
      m_prev = m_filt;
      if ((m_cyc % div) == div - 1) begin
        if (samp == m_filt) m_run = 0;
        else begin
          m_run++;
          if (m_run == 6) begin m_filt = samp; m_run = 0; end
        end
      end
      void'(m_hist.pop_front());
      m_hist.push_back(int'(fault_pin));
      if (!pwm_run) m_mode = int'(act_type);
      m_cyc = (m_cyc + 1) % 128;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int eoe;
      eoe = m_oe ? (1 << NPH) - 1 : 0;
      n_cmp++;
      if (int'(pwm_up_o) != m_up || int'(pwm_dn_o) != m_dn ||
          int'(pwm_up_oe) != eoe || int'(pwm_dn_oe) != eoe ||
          int'(fault_active) != m_fault || int'(fault_flag) != m_flag) begin
        n_bad++;
        $display("FAIL model R1..R11 t=%0t got up=%b dn=%b oe=%b/%b f=%b fl=%b exp up=%0d dn=%0d oe=%0d f=%0d fl=%0d",
                 $time, pwm_up_o, pwm_dn_o, pwm_up_oe, pwm_dn_oe, fault_active,
                 fault_flag, m_up, m_dn, eoe, m_fault, m_flag);
      end
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int got, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic low_pulse(int n);
    fault_pin = 1'b0; ticks(n); fault_pin = 1'b1;
  endtask

  task automatic clear();
    flag_clr = 1'b1; ticks(1); flag_clr = 1'b0; ticks(1);
  endtask

  initial begin
    fork
      begin
        ticks(3);
        check(pwm_up_oe == 0 && fault_active == 0 && fault_flag == 0 && pwm_up_o == 0,
              "R11 reset state", int'(pwm_up_oe), 0);
        rst = 1'b0;
        ticks(20);
        check(&pwm_up_oe && &pwm_dn_oe, "R11 enables after reset", int'(pwm_up_oe), 7);
        // R9 polarity
        pol_up = 1'b1; pwm_up = 3'b101; pol_dn = 1'b0; pwm_dn = 3'b011;
        ticks(1);
        check(pwm_up_o == 3'b010, "R9 upper polarity", int'(pwm_up_o), 2);
        check(pwm_dn_o == 3'b011, "R9 lower polarity", int'(pwm_dn_o), 3);
        // R1 glitch of 5 samples
        low_pulse(5); ticks(20);
        check(fault_active == 0 && fault_flag == 0, "R1 short pulse dropped", int'(fault_active), 0);
        // R3 falling edge latch, R7 shutdown
        low_pulse(10); ticks(3);
        check(fault_active == 1, "R3 falling edge latched", int'(fault_active), 1);
        check(pwm_up_oe == 0 && pwm_dn_oe == 0, "R7 shutdown on fault", int'(pwm_up_oe), 0);
        ticks(20);
        check(fault_active == 1, "R3 latch holds", int'(fault_active), 1);
        clear();
        check(fault_active == 0 && &pwm_up_oe, "R3 cleared", int'(fault_active), 0);
        // R7 without shutdown
        shut_en = 1'b0;
        low_pulse(12); ticks(2);
        check(fault_active == 1 && &pwm_up_oe && &pwm_dn_oe, "R7 no shutdown keeps drive",
              int'(pwm_up_oe), 7);
        ticks(15); clear(); shut_en = 1'b1;
        // R10 request ignored while running
        pwm_run = 1'b1; act_type = 2'b01; ticks(2);
        low_pulse(10); ticks(3);
        check(fault_active == 1, "R10 mode request ignored while running", int'(fault_active), 1);
        ticks(15); clear();
        // R4 rising edge after mode is captured
        pwm_run = 1'b0; ticks(2);
        fault_pin = 1'b0; ticks(15);
        check(fault_active == 0, "R4 falling edge ignored in rise mode", int'(fault_active), 0);
        fault_pin = 1'b1; ticks(12);
        check(fault_active == 1, "R4 rising edge latched", int'(fault_active), 1);
        clear();
        // R5 level modes
        act_type = 2'b11; ticks(3);
        check(fault_active == 1 && fault_flag == 1, "R5 high level fault", int'(fault_active), 1);
        fault_pin = 1'b0; ticks(12);
        check(fault_active == 0, "R5 level fault follows input", int'(fault_active), 0);
        check(fault_flag == 1, "R5 flag sticky", int'(fault_flag), 1);
        clear();
        check(fault_flag == 0, "R5 flag cleared", int'(fault_flag), 0);
        act_type = 2'b10; ticks(3);
        check(fault_active == 1, "R5 low level fault", int'(fault_active), 1);
        // R6 detection disabled
        det_en = 1'b0; ticks(2);
        check(fault_active == 0 && &pwm_up_oe, "R6 level fault suppressed", int'(fault_active), 0);
        clear(); ticks(5);
        check(fault_flag == 0, "R6 no new flag", int'(fault_flag), 0);
        // R8 force off
        out_force_off = 1'b1; ticks(2);
        check(pwm_up_oe == 0 && pwm_dn_oe == 0, "R8 forced off", int'(pwm_up_oe), 0);
        out_force_off = 1'b0; ticks(2);
        check(&pwm_up_oe, "R8 released", int'(pwm_up_oe), 7);
        // R2 divided sampling
        fault_pin = 1'b1; act_type = 2'b00; det_en = 1'b1; filt_div_sel = 3'd3;
        ticks(80); clear();
        low_pulse(32); ticks(80);
        check(fault_active == 0, "R2 32-cycle pulse dropped at div 8", int'(fault_active), 0);
        low_pulse(60); ticks(20);
        check(fault_active == 1, "R2 60-cycle pulse accepted at div 8", int'(fault_active), 1);
        ticks(5); clear();
        check(fault_active == 0, "R2 cleared", int'(fault_active), 0);
        ticks(5);
      end
      begin
        ticks(20000);
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule